// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Word Link

This block carries an N-bit word across a two-phase, level-encoded dual-rail link and gives both ends of it. Every bit travels on a pair of wires: a value wire, which always holds the logical bit, and a phase wire. Each new token flips exactly one wire of every pair. If the bit's value changed, the value wire flips. If it did not, the phase wire flips. The XOR of the two wires of a bit is therefore that bit's token parity, and the parity alternates from token to token. No return-to-zero step is ever inserted.

The sending side takes a word on a valid/ready handshake and drives the next codeword onto the link. The receiving side checks that every bit pair shows the same parity and that this parity differs from the last token it took. When both hold, it presents the word for one cycle and flips a single two-phase acknowledge wire. The sender may launch again only once the acknowledge parity equals the parity it last sent. Both ends are clocked registers, and the link wires are brought out so that the codewords can be observed.

Top module: `ledr_link`

## Requirements
- R1: After reset, all value and phase wires read 0, the acknowledge reads 0, `in_ready` is 1 and `out_valid` is 0.
- R2: One cycle after a word is accepted (`in_valid` and `in_ready` both high at a clock edge), `link_data` equals that word.
- R3: For a bit whose new value differs from the value previously sent, the value wire flips and the phase wire keeps its level.
- R4: For a bit whose new value equals the value previously sent, the phase wire flips and the value wire keeps its level.
- R5: On every launch, exactly one of the two wires of each bit changes. Outside a launch, neither wire changes.
- R6: `in_ready` is high exactly when the acknowledge level equals the parity of the last sent token. `in_ready` is therefore low in the cycle after a launch. A word offered while `in_ready` is low leaves the link wires unchanged.
- R7: The cycle after a launch, the receiver accepts the token. In the following cycle `out_valid` is 1 and `out_word` equals the sent word. `out_valid` falls again at the next edge if no new token arrives.
- R8: `link_ack` flips once for each token the receiver accepts, so after an acceptance it equals the sent token's parity, and it holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sender offers `in_word` |
| in_word | input | W | Word to send |
| in_ready | output | 1 | Sender can launch a token |
| out_valid | output | 1 | One-cycle pulse: a new word was received |
| out_word | output | W | Last received word |
| link_data | output | W | Value wires of the link |
| link_phase | output | W | Phase wires of the link |
| link_ack | output | 1 | Two-phase acknowledge wire |

## Verification
Two things can happen inside one token: value-wire flips on the bits that changed, and phase-wire flips on the bits that did not. The sweeps send word sequences that mix both kinds in every proportion, including all-same and all-different successors. The bench then recomputes each bit's expected pair and checks that each pair changed in exactly one wire. The handshake can also meet a pending offer in the same cycle as the acknowledge is still outstanding. This is provoked by holding `in_valid` with a different word through the acknowledge cycle, and it is judged by the link wires staying put.

// File: rtl/ledr_pkg.sv
package ledr_pkg;

  // next phase level of one bit pair: phase flips when the value repeats
  function automatic logic bit_phase_next(input logic d_old, input logic p_old,
                                          input logic d_new);
    return p_old ^ ~(d_old ^ d_new);
  endfunction

  // token parity carried by one bit pair
  function automatic logic bit_parity(input logic d, input logic p);
    return d ^ p;
  endfunction

endpackage

// File: rtl/ledr_complete.sv
module ledr_complete #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic [W-1:0] p,
  output logic         all_odd,
  output logic         all_even
);
  import ledr_pkg::*;

  logic [W-1:0] par_vec;

  for (genvar b = 0; b < W; b++) begin : g_par
    assign par_vec[b] = bit_parity(d[b], p[b]);
  end

  assign all_odd  = &par_vec;
  assign all_even = ~|par_vec;
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  logic         ack,
  output logic         in_ready,
  output logic         launch,
  output logic [W-1:0] tx_data,
  output logic [W-1:0] tx_phase
);
  import ledr_pkg::*;

  logic         sent_par;
  logic [W-1:0] phase_nx;

  assign in_ready = (ack == sent_par);
  assign launch   = in_valid && in_ready;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign phase_nx[b] = bit_phase_next(tx_data[b], tx_phase[b], in_word[b]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_phase <= '0;
      sent_par <= 1'b0;
    end else if (launch) begin
      tx_data  <= in_word;
      tx_phase <= phase_nx;
      sent_par <= ~sent_par;
    end
  end

  p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> tx_data == $past(in_word));

  p_one_wire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> ((tx_data ^ $past(tx_data)) ^ (tx_phase ^ $past(tx_phase))) == {W{1'b1}});

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(tx_data) && $stable(tx_phase));

  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !in_ready);
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] rx_phase,
  output logic         accept,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic         ack
);
  logic all_odd, all_even;

  ledr_complete #(.W(W)) u_complete (
    .d        (rx_data),
    .p        (rx_phase),
    .all_odd  (all_odd),
    .all_even (all_even)
  );

  // ack level equals the parity of the last accepted token
  assign accept = (all_odd && !ack) || (all_even && ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      ack       <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_word <= rx_data;
        ack      <= ~ack;
      end
    end
  end

  p_deliver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && out_word == $past(rx_data));

  p_ack_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ack != $past(ack));

  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ack) && !out_valid);
endmodule

// File: rtl/ledr_link.sv
module ledr_link #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic [W-1:0] link_data,
  output logic [W-1:0] link_phase,
  output logic         link_ack
);
  logic launch;
  logic accept;

  ledr_tx #(.W(W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_word  (in_word),
    .ack      (link_ack),
    .in_ready (in_ready),
    .launch   (launch),
    .tx_data  (link_data),
    .tx_phase (link_phase)
  );

  ledr_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (link_data),
    .rx_phase  (link_phase),
    .accept    (accept),
    .out_valid (out_valid),
    .out_word  (out_word),
    .ack       (link_ack)
  );

  p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> accept);

  p_one_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !accept);
endmodule

// File: tb/tb_ledr_link.sv
module tb_ledr_link;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         in_ready, out_valid, link_ack;
  logic [W-1:0] out_word, link_data, link_phase;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] m_data  = '0;
  logic [W-1:0] m_phase = '0;
  logic         m_par   = 1'b0;

  always #10 clk = ~clk;

  ledr_link #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
    .link_data(link_data), .link_phase(link_phase), .link_ack(link_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; leaves the bench at a negedge
  task automatic send(input logic [W-1:0] w, input bit hold);
    logic [W-1:0] exp_ph;
    logic [W-1:0] od, op;
    chk("R6 ready before launch", {31'd0, in_ready}, 32'd1);
    od = m_data;
    op = m_phase;
    for (int b = 0; b < W; b++)
      exp_ph[b] = (w[b] == od[b]) ? ~op[b] : op[b];
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk); @(negedge clk);
    m_data  = w;
    m_phase = exp_ph;
    m_par   = ~m_par;
    chk("R2 value wires", {24'd0, link_data}, {24'd0, w});
    chk("R3/R4 phase wires", {24'd0, link_phase}, {24'd0, exp_ph});
    chk("R5 one wire per bit", {24'd0, (link_data ^ od) ^ (link_phase ^ op)}, {24'd0, {W{1'b1}}});
    chk("R6 busy after launch", {31'd0, in_ready}, 32'd0);
    if (hold) in_word = ~w;
    else in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (hold) begin
      chk("R6 offer ignored data", {24'd0, link_data}, {24'd0, w});
      chk("R6 offer ignored phase", {24'd0, link_phase}, {24'd0, exp_ph});
    end
    chk("R7 out_valid", {31'd0, out_valid}, 32'd1);
    chk("R7 out_word", {24'd0, out_word}, {24'd0, w});
    chk("R8 ack parity", {31'd0, link_ack}, {31'd0, m_par});
    chk("R6 ready after ack", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic idle_check();
    @(posedge clk); @(negedge clk);
    chk("R7 pulse ends", {31'd0, out_valid}, 32'd0);
    chk("R8 ack holds", {31'd0, link_ack}, {31'd0, m_par});
    chk("R5 wires hold", {24'd0, link_data ^ link_phase}, {24'd0, {W{m_par}}});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 data", {24'd0, link_data}, 32'd0);
    chk("R1 phase", {24'd0, link_phase}, 32'd0);
    chk("R1 ack", {31'd0, link_ack}, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, in_ready}, 32'd1);
    chk("R1 no spurious word", {31'd0, out_valid}, 32'd0);
    // repeat of reset value: all phase wires flip (R4)
    send(8'h00, 1'b0);
    // all bits change (R3)
    send(8'hFF, 1'b0);
    send(8'h00, 1'b1);
    // ascending sweep: mixed value/phase flips
    for (int i = 0; i < 256; i++) begin
      send(i[W-1:0], i[2]);
      if (i % 16 == 0) idle_check();
    end
    // scrambled sweep
    for (int i = 0; i < 256; i++) begin
      send(W'((i * 37 + 11) & 255), i[0]);
      send(W'((i * 37 + 11) & 255), 1'b0);
    end
    idle_check();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule